// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block sits between the event outputs of a serial bus protocol engine and a host processor. Each engine condition arrives as a single-cycle pulse. A pulse is kept in a sticky status bit only if the host has enabled that condition in its mask register. The block drives one active-high interrupt request that summarises every kept condition that is still enabled.

The host reaches the block through a small 16-bit register port. The port has three locations: the enable mask (read/write), the status word (read-only) and a write-only command word. The status word puts each condition at the same bit position it has in the mask and adds a summary bit in the top position. One read therefore tells the host whether a request is active and what caused it. Kept conditions are not cleared by reading or by write-one-to-clear. They are cleared by an interrupt-reset bit in the command word. A separate software-reset bit in the same word returns the whole block to its idle state.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the mask reads 0x0000, the status reads 0x0000 and `irqOut` is low.
- R2: A write to offset 0x00 loads data bits 14:0 into the mask. A read of offset 0x00 returns the mask in bits 14:0, and bit 15 always reads 0.
- R3: A pulse on `evtPulse[i]` while mask bit i is set makes status bit i read 1 from the next cycle on. The bit stays set until a clear command arrives.
- R4: Status bit 15 is 1 exactly when some status bit in 14:0 is set and its mask bit is also set. `irqOut` always equals status bit 15 and rises in the cycle after the edge that captured the event.
- R5: Clearing a mask bit does not drop a status bit that is already set. It only removes that bit from the summary bit and from `irqOut`.
- R6: Writing offset 0x03 with data bit 2 set clears all status bits. An enabled event in that same cycle is still captured.
- R7: Writing offset 0x03 with data bit 0 set clears the mask, the status and `irqOut`. Events in that cycle are discarded.
- R8: Writes to offset 0x07 have no effect. Reads of offset 0x03 and of every unmapped offset return 0x0000.
- R9: A pulse on a condition whose mask bit is clear is lost. Enabling that bit later does not make it appear in the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 15 | Single-cycle event pulses, one per condition |
| hostWrEn | input | 1 | Host write strobe for the current cycle |
| hostAddr | input | 5 | Host register offset |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Combinational read data for `hostAddr` |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
The assertions assume that `hostAddr`, `hostWrEn` and `hostWrData` are defined on every clock edge. They also assume that each event line holds a pulse for only the cycle in which the condition occurs, so a line that stays high is treated as a new event on every edge. The stimulus drives every input on each falling edge with a known value. Random traffic draws event vectors as sparse ANDs of random words and aims writes mostly at the three mapped offsets, with a software reset only on rare draws. Directed steps then cover the same-cycle reset-and-event case and the order of operations in which a mask bit is disabled and later enabled again.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam logic [4:0] OFF_MASK   = 5'h00;
  localparam logic [4:0] OFF_CMD    = 5'h03;
  localparam logic [4:0] OFF_STATUS = 5'h07;

  localparam int CMD_SWRST_BIT  = 0;
  localparam int CMD_INTRST_BIT = 2;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_MASK   = 2'd1,
    RD_STATUS = 2'd2
  } rdSel_t;

  typedef struct packed {
    logic   maskWr;
    logic   intClear;
    logic   swReset;
    rdSel_t rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int AddrWidth = 5,
  parameter int DataWidth = 16
) (
  input  logic                 hostWrEn,
  input  logic [AddrWidth-1:0] hostAddr,
  input  logic [DataWidth-1:0] hostWrData,
  output ctrlStrobes_t         strobes
);

  localparam logic [AddrWidth-1:0] MaskAddr   = AddrWidth'(OFF_MASK);
  localparam logic [AddrWidth-1:0] CmdAddr    = AddrWidth'(OFF_CMD);
  localparam logic [AddrWidth-1:0] StatusAddr = AddrWidth'(OFF_STATUS);

  logic hitMask;
  logic hitCmd;
  logic hitStatus;

  always_comb begin
    hitMask   = (hostAddr == MaskAddr);
    hitCmd    = (hostAddr == CmdAddr);
    hitStatus = (hostAddr == StatusAddr);
  end

  always_comb begin
    strobes          = '0;
    strobes.maskWr   = hostWrEn && hitMask;
    strobes.intClear = hostWrEn && hitCmd && hostWrData[CMD_INTRST_BIT];
    strobes.swReset  = hostWrEn && hitCmd && hostWrData[CMD_SWRST_BIT];
    if (hitMask)        strobes.rdSel = RD_MASK;
    else if (hitStatus) strobes.rdSel = RD_STATUS;
    else                strobes.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int CondCount = 15,
  parameter int DataWidth = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [DataWidth-1:0] wrData,
  input  logic [CondCount-1:0] evtPulse,
  output logic [DataWidth-1:0] rdData,
  output logic                 irq
);

  localparam int MasterBit = DataWidth - 1;

  logic [CondCount-1:0] maskQ;
  logic [CondCount-1:0] maskNext;
  logic [CondCount-1:0] latchQ;
  logic [CondCount-1:0] latchNext;
  logic                 irqQ;

  // Mask next state: software reset wins, otherwise a host write loads it.
  always_comb begin
    if (strobes.swReset)     maskNext = '0;
    else if (strobes.maskWr) maskNext = wrData[CondCount-1:0];
    else                     maskNext = maskQ;
  end

  // One sticky cell per condition; a new enabled event survives a clear.
  for (genvar i = 0; i < CondCount; i++) begin : g_cell
    logic captureEvt;
    assign captureEvt = evtPulse[i] && maskQ[i];
    always_comb begin
      if (strobes.swReset)       latchNext[i] = 1'b0;
      else if (strobes.intClear) latchNext[i] = captureEvt;
      else                       latchNext[i] = latchQ[i] || captureEvt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '0;
      latchQ <= '0;
      irqQ   <= 1'b0;
    end else begin
      maskQ  <= maskNext;
      latchQ <= latchNext;
      irqQ   <= |(latchNext & maskNext);
    end
  end

  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      RD_MASK: rdData[CondCount-1:0] = maskQ;
      RD_STATUS: begin
        rdData[CondCount-1:0] = latchQ;
        rdData[MasterBit]     = irqQ;
      end
      default: rdData = '0;
    endcase
  end

  assign irq = irqQ;

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqc_pkg::*;
#(
  parameter int CondCount = 15,
  parameter int DataWidth = 16,
  parameter int AddrWidth = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CondCount-1:0] evtPulse,
  input  logic                 hostWrEn,
  input  logic [AddrWidth-1:0] hostAddr,
  input  logic [DataWidth-1:0] hostWrData,
  output logic [DataWidth-1:0] hostRdData,
  output logic                 irqOut
);

  ctrlStrobes_t strobes;

  irqc_ctrl #(
    .AddrWidth(AddrWidth),
    .DataWidth(DataWidth)
  ) i_ctrl (
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .strobes   (strobes)
  );

  irqc_datapath #(
    .CondCount(CondCount),
    .DataWidth(DataWidth)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (hostWrData),
    .evtPulse(evtPulse),
    .rdData  (hostRdData),
    .irq     (irqOut)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int CondCount = 15,
  parameter int DataWidth = 16,
  parameter int AddrWidth = 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [CondCount-1:0] evtPulse,
  input logic                 hostWrEn,
  input logic [AddrWidth-1:0] hostAddr,
  input logic [DataWidth-1:0] hostWrData,
  input logic [DataWidth-1:0] hostRdData,
  input logic                 irqOut
);

  logic atMask;
  logic atCmd;
  logic atStatus;
  logic swRstWr;
  logic intRstWr;
  logic maskWr;

  assign atMask   = (hostAddr == AddrWidth'(5'h00));
  assign atCmd    = (hostAddr == AddrWidth'(5'h03));
  assign atStatus = (hostAddr == AddrWidth'(5'h07));
  assign swRstWr  = hostWrEn && atCmd && hostWrData[0];
  assign intRstWr = hostWrEn && atCmd && hostWrData[2];
  assign maskWr   = hostWrEn && atMask;

  p_mask_top_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    atMask |-> (hostRdData[DataWidth-1] == 1'b0));

  p_irq_is_master_r4: assert property (@(posedge clk) disable iff (!rstN)
    atStatus |-> (hostRdData[DataWidth-1] == irqOut));

  p_no_rise_without_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse == '0 && !maskWr) |=> !$rose(irqOut));

  p_int_clear_drops_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    (intRstWr && evtPulse == '0) |=> !irqOut);

  p_sw_reset_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    swRstWr |=> !irqOut);

  p_unmapped_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!atMask && !atStatus) |-> (hostRdData == '0));

endmodule

bind irq_status_ctrl irqc_checker #(
  .CondCount(CondCount),
  .DataWidth(DataWidth),
  .AddrWidth(AddrWidth)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .evtPulse  (evtPulse),
  .hostWrEn  (hostWrEn),
  .hostAddr  (hostAddr),
  .hostWrData(hostWrData),
  .hostRdData(hostRdData),
  .irqOut    (irqOut)
);

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] evtPulse = '0;
  logic        hostWrEn = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [14:0] mMask = '0;
  logic [14:0] mLat = '0;
  logic        mIrq = 1'b0;

  always #10 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .hostWrEn(hostWrEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .irqOut(irqOut)
  );

  function automatic logic [15:0] expRead(input logic [4:0] a);
    if (a == 5'h00) return {1'b0, mMask};
    if (a == 5'h07) return {mIrq, mLat};
    return 16'h0000;
  endfunction

  task automatic modelStep(input logic we, input logic [4:0] a,
                           input logic [15:0] d, input logic [14:0] e);
    logic sw, ic, mw;
    logic [14:0] nm, nl;
    sw = we && a == 5'h03 && d[0];
    ic = we && a == 5'h03 && d[2];
    mw = we && a == 5'h00;
    nm = sw ? 15'h0 : (mw ? d[14:0] : mMask);
    nl = sw ? 15'h0 : ((ic ? 15'h0 : mLat) | (e & mMask));
    mMask = nm;
    mLat  = nl;
    mIrq  = |(nl & nm);
  endtask

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called just after a falling edge: drive, cross one rising edge, update model.
  task automatic step(input logic we, input logic [4:0] a,
                      input logic [15:0] d, input logic [14:0] e);
    hostWrEn = we; hostAddr = a; hostWrData = d; evtPulse = e;
    @(posedge clk);
    modelStep(we, a, d, e);
    @(negedge clk);
    hostWrEn = 1'b0; evtPulse = '0;
  endtask

  task automatic readCheck(input string tag, input logic [4:0] a, input logic [15:0] exp);
    hostWrEn = 1'b0; evtPulse = '0; hostAddr = a;
    #1;
    check(tag, hostRdData, exp);
  endtask

  task automatic irqCheck(input string tag, input logic exp);
    check(tag, {15'h0, irqOut}, {15'h0, exp});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readCheck("R1 mask", 5'h00, 16'h0000);
    readCheck("R1 status", 5'h07, 16'h0000);
    irqCheck("R1 irq", 1'b0);

    // R2 mask write / read, bit 15 reads 0
    step(1, 5'h00, 16'hFFFF, '0);
    readCheck("R2 mask all", 5'h00, 16'h7FFF);
    step(1, 5'h00, 16'h0005, '0);
    readCheck("R2 mask 0005", 5'h00, 16'h0005);

    // R3/R4 enabled events captured, master and irq follow
    step(0, 5'h07, 16'h0, 15'h0007);
    readCheck("R3 status", 5'h07, 16'h8005);
    irqCheck("R4 irq high", 1'b1);

    // R5 clearing mask keeps latched bits
    step(1, 5'h00, 16'h0004, '0);
    readCheck("R5 partial", 5'h07, 16'h8005);
    step(1, 5'h00, 16'h0000, '0);
    readCheck("R5 unmasked", 5'h07, 16'h0005);
    irqCheck("R5 irq low", 1'b0);

    // R9 masked event is lost
    step(0, 5'h07, 16'h0, 15'h0002);
    step(1, 5'h00, 16'h0002, '0);
    readCheck("R9 dropped", 5'h07, 16'h0005);
    irqCheck("R9 irq low", 1'b0);

    // R6 interrupt reset keeps a same-cycle event
    step(1, 5'h00, 16'h7FFF, '0);
    readCheck("R4 re-enable", 5'h07, 16'h8005);
    step(1, 5'h03, 16'h0004, 15'h0010);
    readCheck("R6 same cycle", 5'h07, 16'h8010);
    step(1, 5'h03, 16'h0004, '0);
    readCheck("R6 cleared", 5'h07, 16'h0000);
    irqCheck("R6 irq low", 1'b0);

    // R7 software reset
    step(1, 5'h00, 16'h0F0F, '0);
    step(0, 5'h07, 16'h0, 15'h0001);
    readCheck("R7 pre", 5'h07, 16'h8001);
    step(1, 5'h03, 16'h0001, 15'h0100);
    readCheck("R7 mask", 5'h00, 16'h0000);
    readCheck("R7 status", 5'h07, 16'h0000);
    irqCheck("R7 irq", 1'b0);

    // R8 read-only status, write-only command, unmapped
    step(1, 5'h00, 16'h0003, '0);
    step(0, 5'h07, 16'h0, 15'h0001);
    step(1, 5'h07, 16'hFFFF, '0);
    readCheck("R8 status write ignored", 5'h07, 16'h8001);
    readCheck("R8 cmd reads zero", 5'h03, 16'h0000);
    readCheck("R8 unmapped", 5'h1F, 16'h0000);
    readCheck("R8 mask intact", 5'h00, 16'h0003);

    // Random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic        we;
      logic [4:0]  a;
      logic [15:0] d;
      logic [14:0] e;
      logic [4:0]  ra;
      we = ($urandom % 3) == 0;
      case ($urandom % 4)
        0: a = 5'h00;
        1: a = 5'h03;
        2: a = 5'h07;
        default: a = 5'($urandom);
      endcase
      d = 16'($urandom);
      if (a == 5'h03 && ($urandom % 25) != 0) d[0] = 1'b0;
      e = 15'($urandom & $urandom & $urandom);
      step(we, a, d, e);
      irqCheck("R4 random irq", mIrq);
      ra = (($urandom % 2) == 0) ? 5'h07 : 5'($urandom);
      readCheck("R3 random read", ra, expRead(ra));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule